// File: doc/BRIEF.md
# Battery-Charger Control Register File

This block holds the few control and status bytes of a battery-charger controller. A serial slave front end, which is not part of this block, passes it three kinds of event: a write-start event at the beginning of each write transfer, the data bytes of that transfer, and a strobe for each byte to be read. The first byte after a write start selects a register. Every later byte is a write to the selected register. Each read strobe returns the selected register one cycle later. After every data byte, read or written, the register pointer moves forward by one. A host can therefore sweep through consecutive registers in one transfer without sending a new address.

Some bit positions do not take the written value. Register 0 keeps its low six bits for good, takes bit 6 from the data and always sets bit 7. Register 4 always sets its top bit. The identity byte is a parameter: software cannot write it, and it can be read at two addresses.

The byte input is a valid/ready stream. A byte moves on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only in a cycle where `rd_req` is high. The read takes that cycle, and the byte must be held until the next cycle. The read side gives no back-pressure: every `rd_req` is taken, and `rsp_valid` is high for exactly one cycle in the cycle after it.

Top module: `chg_regfile`

## Requirements
- R1: After reset, register 0 reads 0xD0, register 1 reads 0x30, register 2 reads 0x0A, register 4 reads 0xA1, and the pointer is 0x00.
- R2: The first byte accepted after a write start loads the register pointer and changes no register.
- R3: A write to register 0 leaves bits [5:0] unchanged, copies bit 6 from the data and sets bit 7 to 1.
- R4: A write to register 4 stores the data with bit 7 forced to 1. Writes to registers 1 and 2 store the data unchanged.
- R5: Address 0x03 and address 0x3B both read the identity parameter (default 0x49). Writes to either address do not change it.
- R6: The pointer increments by one after every accepted data byte and after every read strobe. It wraps from 0xFF to 0x00.
- R7: Every address other than 0x00–0x04 and 0x3B reads as 0x00. Writes to those addresses change no register.
- R8: `rsp_valid` is high in exactly the cycle after each `rd_req`. In that cycle `rsp_data` holds the register that the pointer selected when `rd_req` was high.
- R9: `in_ready` is low in any cycle where `rd_req` is high. A byte offered in that cycle is not consumed, and it takes effect in a later cycle where it is accepted.
- R10: A byte accepted in the same cycle as a write start is treated as the pointer byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Pulse marking the start of a write transfer |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Block can take the incoming byte this cycle |
| in_data | input | 8 | Incoming byte (pointer or write data) |
| rd_req | input | 1 | Strobe requesting one read byte |
| rsp_valid | output | 1 | Read byte valid, one cycle after `rd_req` |
| rsp_data | output | 8 | Read byte |

## Verification
The register pointer can only be seen through the bytes it selects. A pointer that is off by one, fails to advance or fails to wrap shows up on the next read as a wrong `rsp_data`, one cycle after the strobe. A wrong bit mask or a dropped forced bit stays hidden until that register is read back. For this reason every write in the stimulus is followed by a read of the same address. Long runs of auto-incremented writes and reads, and a read across the 0xFF boundary, catch pointer faults within a few bytes of where they occur.

// File: rtl/chg_regfile_pkg.sv
package chg_regfile_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t ADDR_STAT  = 8'h00;
  localparam byte_t ADDR_CTRL  = 8'h01;
  localparam byte_t ADDR_VBAT  = 8'h02;
  localparam byte_t ADDR_IDENT = 8'h03;
  localparam byte_t ADDR_ICHG  = 8'h04;

  localparam byte_t RST_STAT = 8'hD0;
  localparam byte_t RST_CTRL = 8'h30;
  localparam byte_t RST_VBAT = 8'h0A;
  localparam byte_t RST_ICHG = 8'hA1;

  // Register 0: only bit 6 is writable, bit 7 is always set.
  localparam byte_t STAT_WMASK = 8'h40;
  localparam byte_t STAT_FORCE = 8'h80;
  // Register 4: top bit is always set.
  localparam byte_t ICHG_FORCE = 8'h80;

  typedef struct packed {
    byte_t stat;
    byte_t ctrl;
    byte_t vbat;
    byte_t ichg;
  } chg_regs_t;
endpackage

// File: rtl/chg_ptr.sv
module chg_ptr
  import chg_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_start,
  input  logic  byte_acc,
  input  byte_t byte_data,
  input  logic  rd_acc,
  output byte_t ptr,
  output logic  wr_en
);
  logic  first_q;
  logic  load;
  byte_t ptr_q;

  assign load  = byte_acc & (first_q | wr_start);
  assign wr_en = byte_acc & ~load;
  assign ptr   = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      if (byte_acc)      first_q <= 1'b0;
      else if (wr_start) first_q <= 1'b1;

      if (load)                ptr_q <= byte_data;
      else if (wr_en | rd_acc) ptr_q <= ptr_q + 1'b1;
    end
  end

  // R6: every data byte or read moves the pointer by one (with wrap)
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_acc) |=> (ptr_q == byte_t'($past(ptr_q) + 8'd1)));
  // R2: a pointer byte lands in the pointer
  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr_q == $past(byte_data)));
  // R9: a read and a byte are never both accepted
  assert_one_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_acc && byte_acc));
endmodule

// File: rtl/chg_regs.sv
module chg_regs
  import chg_regfile_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  byte_t     addr,
  input  byte_t     wdata,
  output chg_regs_t regs
);
  chg_regs_t q;
  logic known;

  assign regs  = q;
  assign known = (addr == ADDR_STAT) || (addr == ADDR_CTRL) ||
                 (addr == ADDR_VBAT) || (addr == ADDR_ICHG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q.stat <= RST_STAT;
      q.ctrl <= RST_CTRL;
      q.vbat <= RST_VBAT;
      q.ichg <= RST_ICHG;
    end else if (wr_en) begin
      unique case (addr)
        ADDR_STAT: q.stat <= (q.stat & ~(STAT_WMASK | STAT_FORCE)) |
                             (wdata & STAT_WMASK) | STAT_FORCE;
        ADDR_CTRL: q.ctrl <= wdata;
        ADDR_VBAT: q.vbat <= wdata;
        ADDR_ICHG: q.ichg <= wdata | ICHG_FORCE;
        default: ;
      endcase
    end
  end

  // R3: the low six bits of register 0 never move
  assert_stat_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 $stable(q.stat[5:0]));
  // R3: bit 7 of register 0 is always set
  assert_stat_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 q.stat[7]);
  // R4: bit 7 of register 4 is always set
  assert_ichg_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 q.ichg[7]);
  // R7: writes outside the map change nothing
  assert_drop_unknown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !known) |=> $stable(q));
endmodule

// File: rtl/chg_rdmux.sv
module chg_rdmux
  import chg_regfile_pkg::*;
#(
  parameter byte_t IDENT_VAL   = 8'h49,
  parameter byte_t IDENT_ALIAS = 8'h3B
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_req,
  input  byte_t     addr,
  input  chg_regs_t regs,
  output logic      rsp_valid,
  output byte_t     rsp_data
);
  byte_t sel;

  always_comb begin
    if (addr == IDENT_ALIAS) sel = IDENT_VAL;
    else begin
      unique case (addr)
        ADDR_STAT:  sel = regs.stat;
        ADDR_CTRL:  sel = regs.ctrl;
        ADDR_VBAT:  sel = regs.vbat;
        ADDR_IDENT: sel = IDENT_VAL;
        ADDR_ICHG:  sel = regs.ichg;
        default:    sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= sel;
    end
  end

  // R8: one response per strobe, in the next cycle
  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  assert_rsp_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
endmodule

// File: rtl/chg_regfile.sv
module chg_regfile
  import chg_regfile_pkg::*;
#(
  parameter logic [7:0] IDENT_VAL   = 8'h49,
  parameter logic [7:0] IDENT_ALIAS = 8'h3B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_start,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       rd_req,
  output logic       rsp_valid,
  output logic [7:0] rsp_data
);
  byte_t     ptr;
  logic      wr_en;
  logic      byte_acc;
  chg_regs_t regs;

  assign in_ready = ~rd_req;
  assign byte_acc = in_valid & in_ready;

  chg_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .byte_acc(byte_acc),
    .byte_data(in_data), .rd_acc(rd_req), .ptr(ptr), .wr_en(wr_en)
  );

  chg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wdata(in_data),
    .regs(regs)
  );

  chg_rdmux #(.IDENT_VAL(IDENT_VAL), .IDENT_ALIAS(IDENT_ALIAS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .addr(ptr), .regs(regs),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: tb/sim_chg_regfile.sv
module sim_chg_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       rd_req = 1'b0;
  logic       in_ready, rsp_valid;
  logic [7:0] rsp_data;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  chg_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .rd_req(rd_req),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // {op (0 write, 1 read), addr, data-or-expected}
  localparam int NV = 27;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {1'b1, 8'h00, 8'hD0},  // R1
    {1'b1, 8'h01, 8'h30},  // R1
    {1'b1, 8'h02, 8'h0A},  // R1
    {1'b1, 8'h04, 8'hA1},  // R1
    {1'b1, 8'h03, 8'h49},  // R5
    {1'b1, 8'h3B, 8'h49},  // R5
    {1'b1, 8'h07, 8'h00},  // R7
    {1'b0, 8'h00, 8'h00}, {1'b1, 8'h00, 8'h90},  // R3
    {1'b0, 8'h00, 8'hFF}, {1'b1, 8'h00, 8'hD0},  // R3
    {1'b0, 8'h00, 8'h3F}, {1'b1, 8'h00, 8'h90},  // R3
    {1'b0, 8'h01, 8'h5A}, {1'b1, 8'h01, 8'h5A},  // R4
    {1'b0, 8'h02, 8'hC3}, {1'b1, 8'h02, 8'hC3},  // R4
    {1'b0, 8'h04, 8'h12}, {1'b1, 8'h04, 8'h92},  // R4
    {1'b0, 8'h04, 8'h81}, {1'b1, 8'h04, 8'h81},  // R4
    {1'b0, 8'h03, 8'h00}, {1'b1, 8'h03, 8'h49},  // R5
    {1'b0, 8'h3B, 8'h11}, {1'b1, 8'h3B, 8'h49},  // R5
    {1'b0, 8'h20, 8'h77}, {1'b1, 8'h20, 8'h00}   // R7
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic start_x();
    wr_start = 1'b1; @(negedge clk); wr_start = 1'b0;
  endtask
  task automatic put_byte(input logic [7:0] d);
    in_valid = 1'b1; in_data = d; @(negedge clk); in_valid = 1'b0;
  endtask
  task automatic get_byte(output logic [7:0] d);
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    check("R8 rsp_valid", {7'd0, rsp_valid}, 8'h01);
    d = rsp_data;
  endtask
  task automatic set_ptr(input logic [7:0] a);
    start_x(); put_byte(a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle", {7'd0, rsp_valid}, 8'h00);
    check("R9 ready idle", {7'd0, in_ready}, 8'h01);

    // R1: pointer is 0 after reset, so a bare read returns register 0
    get_byte(d); check("R1 ptr reset", d, 8'hD0);

    for (int i = 0; i < NV; i++) begin
      set_ptr(VEC[i][15:8]);
      if (VEC[i][16]) begin
        get_byte(d);
        check($sformatf("vec %0d", i), d, VEC[i][7:0]);
      end else begin
        put_byte(VEC[i][7:0]);
      end
    end
    @(negedge clk);
    check("R8 drop", {7'd0, rsp_valid}, 8'h00);

    // R6 R2: burst write from 0 with auto-increment, then burst read
    set_ptr(8'h00);
    put_byte(8'h40); put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); put_byte(8'h05);
    set_ptr(8'h00);
    get_byte(d); check("R6 burst r0", d, 8'hD0);
    get_byte(d); check("R6 burst r1", d, 8'h11);
    get_byte(d); check("R6 burst r2", d, 8'h22);
    get_byte(d); check("R6 burst r3 ident", d, 8'h49);
    get_byte(d); check("R6 burst r4", d, 8'h85);
    get_byte(d); check("R7 burst r5", d, 8'h00);

    // R6: wrap from 0xFF to 0x00
    set_ptr(8'hFF);
    get_byte(d); check("R6 at FF", d, 8'h00);
    get_byte(d); check("R6 wrap to 00", d, 8'hD0);

    // R9: read and byte together; byte held and accepted next cycle
    set_ptr(8'h01);
    in_valid = 1'b1; in_data = 8'h55; rd_req = 1'b1;
    #1 check("R9 ready low", {7'd0, in_ready}, 8'h00);
    @(negedge clk); rd_req = 1'b0;
    check("R9 read during stall", rsp_data, 8'h11);
    @(negedge clk); in_valid = 1'b0;
    set_ptr(8'h01);
    get_byte(d); check("R9 reg1 untouched", d, 8'h11);
    get_byte(d); check("R9 held byte to reg2", d, 8'h55);

    // R10: start and pointer byte in the same cycle
    wr_start = 1'b1; in_valid = 1'b1; in_data = 8'h02;
    @(negedge clk); wr_start = 1'b0; in_valid = 1'b0;
    get_byte(d); check("R10 same-cycle ptr", d, 8'h55);

    // R2: pointer byte changes no register
    set_ptr(8'h01);
    get_byte(d); check("R2 reg1 intact", d, 8'h11);

    // R1: reset again restores defaults
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    get_byte(d); check("R1 reg0 after reset", d, 8'hD0);
    get_byte(d); check("R1 reg1 after reset", d, 8'h30);
    get_byte(d); check("R1 reg2 after reset", d, 8'h0A);
    set_ptr(8'h04);
    get_byte(d); check("R1 reg4 after reset", d, 8'hA1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule